// File: doc/BRIEF.md
# Multi-Level Page Translation Buffer

This block is a fully associative array of address translations for a three-level virtual memory scheme. The base page is 4 KB and the virtual page number is 27 bits, split into three 9-bit slices. Each way stores a page tag, an address-space identifier, a two-bit page-size level, a physical page number and a permission set. The permission set includes page-fault and access-fault flags captured from the page walker.

Several lookup ports work in parallel and without a clock. Each port compares its request with every way and returns four results: a hit flag, the physical page number built for the matched page size, the permission set, and a vector with one bit per way. One refill port writes a walker response into the way that the replacement logic outside the block selects. The flush input clears either every way or only the non-global ways of one address space. Replacement policy, the page walker and physical-attribute checks belong to the surrounding logic.

Top module: `mlt_array`

## Requirements
- R1: A synchronous active-high reset clears every valid bit. While no way is valid, every port reports no hit, an all-zero way vector, and a PPN and permission set of zero. A port that misses always reports a PPN and permission of zero.
- R2: The stored level controls how many VPN bits take part in matching. Level 0 (1 GB) compares VPN bits 26:18, level 1 (2 MB) compares bits 26:9, and level 2 (4 KB) compares all 27 bits. A way with level code 3 never hits.
- R3: With the default IGNORE_ASID = 0, a hit also requires the stored address-space ID to equal the request's ID.
- R4: The returned PPN depends on the level. Level 0 returns the stored PPN with its low 18 bits replaced by VPN bits 17:0. Level 1 returns the stored PPN with its low 9 bits replaced by VPN bits 8:0. Level 2 returns the stored PPN unchanged.
- R5: On a hit the port returns the 9-bit permission {pf, af, d, a, g, u, x, w, r}, with pf at bit 8, g at bit 4 and r at bit 0. The refill supplies d..r as a 7-bit field {d, a, g, u, x, w, r} with g at bit 4, and supplies pf and af on separate inputs.
- R6: The way vector has a 1 for every valid way that matches. When several ways match, the PPN and permission come from the matching way with the lowest index.
- R7: A refill writes its way on the next rising clock edge and marks that way valid. A lookup in the same cycle as the refill sees the contents from before the write.
- R8: A flush without the address-space qualifier invalidates every way on the next edge.
- R9: A flush with the qualifier invalidates only the ways whose stored ID equals the flush ID and whose g bit is clear. Global ways and ways of other address spaces stay valid.
- R10: When a refill and a flush fall in the same cycle, the refilled way is valid after the edge.
- R11: Each lookup port is independent. Different requests on different ports get their own results in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_vpn | input | NPORTS*27 | Request VPN per port, port p at bits p*27 upward |
| lk_asid | input | NPORTS*ASID_W | Request address-space ID per port |
| lk_hit | output | NPORTS | Hit flag per port |
| lk_ppn | output | NPORTS*PPN_W | Composed physical page number per port |
| lk_perm | output | NPORTS*9 | Permission and fault flags per port |
| lk_way_hit | output | NPORTS*NWAYS | Per-way match vector per port |
| rf_valid | input | 1 | Refill strobe |
| rf_way | input | clog2(NWAYS) | Way to write |
| rf_vpn | input | 27 | Walker tag |
| rf_asid | input | ASID_W | Address-space ID of the refill |
| rf_level | input | 2 | Page-size level code |
| rf_ppn | input | PPN_W | Walker physical page number |
| rf_perm | input | 7 | {d, a, g, u, x, w, r} |
| rf_pf | input | 1 | Page-fault flag to store |
| rf_af | input | 1 | Access-fault flag to store |
| fl_valid | input | 1 | Flush strobe |
| fl_use_asid | input | 1 | Limit the flush to one address space |
| fl_asid | input | ASID_W | Address space to flush |

## Verification
The hardest cases to reach are those where the level decides the result. A request that differs from a stored tag only in bits below the compared range must still hit, and its PPN must carry those bits. A flip one bit higher must miss. The bench stores one entry of each level and then probes each with its own tag and with every single-bit variant of that tag, on both ports at once. It then sets up overlapping entries, same-cycle refill and lookup, same-cycle refill and flush, and a selective flush in which global and non-global ways of one ID sit next to ways of another ID.

// File: rtl/mlt_pkg.sv
package mlt_pkg;
  localparam int SLICE_W = 9;
  localparam int LEVELS  = 3;
  localparam int VPN_W   = SLICE_W * LEVELS;
  localparam int LVL_W   = 2;
  localparam int PTE_PERM_W = 7;

  typedef struct packed {
    logic pf;
    logic af;
    logic d;
    logic a;
    logic g;
    logic u;
    logic x;
    logic w;
    logic r;
  } mlt_perm_t;

  localparam int PERM_W = $bits(mlt_perm_t);
  localparam int G_BIT  = 4;
endpackage

// File: rtl/mlt_store.sv
module mlt_store
  import mlt_pkg::*;
#(
  parameter int NWAYS  = 8,
  parameter int ASID_W = 16,
  parameter int PPN_W  = 24,
  localparam int WAY_W = (NWAYS > 1) ? $clog2(NWAYS) : 1
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              rf_valid,
  input  logic [WAY_W-1:0]                  rf_way,
  input  logic [VPN_W-1:0]                  rf_vpn,
  input  logic [ASID_W-1:0]                 rf_asid,
  input  logic [LVL_W-1:0]                  rf_level,
  input  logic [PPN_W-1:0]                  rf_ppn,
  input  mlt_perm_t                         rf_perm,
  input  logic                              fl_valid,
  input  logic                              fl_use_asid,
  input  logic [ASID_W-1:0]                 fl_asid,
  output logic [NWAYS-1:0]                  st_valid,
  output logic [NWAYS-1:0][VPN_W-1:0]       st_vpn,
  output logic [NWAYS-1:0][ASID_W-1:0]      st_asid,
  output logic [NWAYS-1:0][LVL_W-1:0]       st_lvl,
  output logic [NWAYS-1:0][PPN_W-1:0]       st_ppn,
  output mlt_perm_t [NWAYS-1:0]             st_perm
);
  logic [NWAYS-1:0] drop;
  logic             way_ok;

  assign way_ok = (32'(rf_way) < NWAYS);

  always_comb begin
    for (int w = 0; w < NWAYS; w++) begin
      drop[w] = fl_valid &&
                (!fl_use_asid || (st_asid[w] == fl_asid && !st_perm[w].g));
    end
  end

  // Valid bits: flush first, a refill of the same cycle overrides it.
  always_ff @(posedge clk) begin
    if (rst) begin
      st_valid <= '0;
    end else begin
      for (int w = 0; w < NWAYS; w++) begin
        if (drop[w]) st_valid[w] <= 1'b0;
      end
      if (rf_valid && way_ok) st_valid[rf_way] <= 1'b1;
    end
  end

  // Payload has no reset; only the valid bits qualify it.
  always_ff @(posedge clk) begin
    if (rf_valid && way_ok) begin
      st_vpn[rf_way]  <= rf_vpn;
      st_asid[rf_way] <= rf_asid;
      st_lvl[rf_way]  <= rf_level;
      st_ppn[rf_way]  <= rf_ppn;
      st_perm[rf_way] <= rf_perm;
    end
  end
endmodule

// File: rtl/mlt_way_match.sv
module mlt_way_match
  import mlt_pkg::*;
#(
  parameter int ASID_W      = 16,
  parameter int PPN_W       = 24,
  parameter bit IGNORE_ASID = 1'b0
) (
  input  logic              e_valid,
  input  logic [VPN_W-1:0]  e_vpn,
  input  logic [ASID_W-1:0] e_asid,
  input  logic [LVL_W-1:0]  e_lvl,
  input  logic [PPN_W-1:0]  e_ppn,
  input  logic [VPN_W-1:0]  q_vpn,
  input  logic [ASID_W-1:0] q_asid,
  output logic              hit,
  output logic [PPN_W-1:0]  ppn
);
  logic [LEVELS-1:0] slice_eq;
  logic              tag_ok;
  logic              asid_ok;

  // Slice 0 is the most significant VPN slice.
  for (genvar s = 0; s < LEVELS; s++) begin : g_slice
    assign slice_eq[s] = (e_vpn[VPN_W-1-s*SLICE_W -: SLICE_W] ==
                          q_vpn[VPN_W-1-s*SLICE_W -: SLICE_W]);
  end

  always_comb begin
    tag_ok = 1'b0;
    for (int l = 0; l < LEVELS; l++) begin
      if (e_lvl == LVL_W'(l)) begin
        tag_ok = 1'b1;
        for (int s = 0; s < LEVELS; s++) begin
          if (s <= l) tag_ok = tag_ok & slice_eq[s];
        end
      end
    end
  end

  if (IGNORE_ASID) begin : g_noasid
    assign asid_ok = 1'b1;
  end else begin : g_asid
    assign asid_ok = (e_asid == q_asid);
  end

  assign hit = e_valid & tag_ok & asid_ok;

  // Huge pages take their low PPN bits from the request.
  always_comb begin
    ppn = e_ppn;
    for (int l = 0; l < LEVELS; l++) begin
      if (e_lvl == LVL_W'(l)) begin
        for (int b = 0; b < PPN_W; b++) begin
          if (b < (LEVELS - 1 - l) * SLICE_W && b < VPN_W) ppn[b] = q_vpn[b];
        end
      end
    end
  end
endmodule

// File: rtl/mlt_port_sel.sv
module mlt_port_sel
  import mlt_pkg::*;
#(
  parameter int NWAYS = 8,
  parameter int PPN_W = 24
) (
  input  logic [NWAYS-1:0]            hit_vec,
  input  logic [NWAYS-1:0][PPN_W-1:0] ppn_arr,
  input  mlt_perm_t [NWAYS-1:0]       perm_arr,
  output logic                        hit,
  output logic [PPN_W-1:0]            ppn,
  output mlt_perm_t                   perm
);
  assign hit = |hit_vec;

  // Scan downwards so the lowest matching way is assigned last.
  always_comb begin
    ppn  = '0;
    perm = '0;
    for (int w = NWAYS - 1; w >= 0; w--) begin
      if (hit_vec[w]) begin
        ppn  = ppn_arr[w];
        perm = perm_arr[w];
      end
    end
  end
endmodule

// File: rtl/mlt_array.sv
module mlt_array
  import mlt_pkg::*;
#(
  parameter int NWAYS       = 8,
  parameter int NPORTS      = 2,
  parameter int ASID_W      = 16,
  parameter int PPN_W       = 24,
  parameter bit IGNORE_ASID = 1'b0,
  localparam int WAY_W = (NWAYS > 1) ? $clog2(NWAYS) : 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NPORTS*VPN_W-1:0]    lk_vpn,
  input  logic [NPORTS*ASID_W-1:0]   lk_asid,
  output logic [NPORTS-1:0]          lk_hit,
  output logic [NPORTS*PPN_W-1:0]    lk_ppn,
  output logic [NPORTS*PERM_W-1:0]   lk_perm,
  output logic [NPORTS*NWAYS-1:0]    lk_way_hit,
  input  logic                       rf_valid,
  input  logic [WAY_W-1:0]           rf_way,
  input  logic [VPN_W-1:0]           rf_vpn,
  input  logic [ASID_W-1:0]          rf_asid,
  input  logic [LVL_W-1:0]           rf_level,
  input  logic [PPN_W-1:0]           rf_ppn,
  input  logic [PTE_PERM_W-1:0]      rf_perm,
  input  logic                       rf_pf,
  input  logic                       rf_af,
  input  logic                       fl_valid,
  input  logic                       fl_use_asid,
  input  logic [ASID_W-1:0]          fl_asid
);
  logic [NWAYS-1:0]             st_valid;
  logic [NWAYS-1:0][VPN_W-1:0]  st_vpn;
  logic [NWAYS-1:0][ASID_W-1:0] st_asid;
  logic [NWAYS-1:0][LVL_W-1:0]  st_lvl;
  logic [NWAYS-1:0][PPN_W-1:0]  st_ppn;
  mlt_perm_t [NWAYS-1:0]        st_perm;
  mlt_perm_t                    rf_full_perm;

  assign rf_full_perm = {rf_pf, rf_af, rf_perm};

  mlt_store #(
    .NWAYS (NWAYS),
    .ASID_W(ASID_W),
    .PPN_W (PPN_W)
  ) u_store (
    .clk        (clk),
    .rst        (rst),
    .rf_valid   (rf_valid),
    .rf_way     (rf_way),
    .rf_vpn     (rf_vpn),
    .rf_asid    (rf_asid),
    .rf_level   (rf_level),
    .rf_ppn     (rf_ppn),
    .rf_perm    (rf_full_perm),
    .fl_valid   (fl_valid),
    .fl_use_asid(fl_use_asid),
    .fl_asid    (fl_asid),
    .st_valid   (st_valid),
    .st_vpn     (st_vpn),
    .st_asid    (st_asid),
    .st_lvl     (st_lvl),
    .st_ppn     (st_ppn),
    .st_perm    (st_perm)
  );

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    logic [NWAYS-1:0]            way_hit;
    logic [NWAYS-1:0][PPN_W-1:0] way_ppn;
    mlt_perm_t                   sel_perm;

    for (genvar w = 0; w < NWAYS; w++) begin : g_way
      mlt_way_match #(
        .ASID_W     (ASID_W),
        .PPN_W      (PPN_W),
        .IGNORE_ASID(IGNORE_ASID)
      ) u_match (
        .e_valid(st_valid[w]),
        .e_vpn  (st_vpn[w]),
        .e_asid (st_asid[w]),
        .e_lvl  (st_lvl[w]),
        .e_ppn  (st_ppn[w]),
        .q_vpn  (lk_vpn[p*VPN_W +: VPN_W]),
        .q_asid (lk_asid[p*ASID_W +: ASID_W]),
        .hit    (way_hit[w]),
        .ppn    (way_ppn[w])
      );
    end

    mlt_port_sel #(
      .NWAYS(NWAYS),
      .PPN_W(PPN_W)
    ) u_sel (
      .hit_vec (way_hit),
      .ppn_arr (way_ppn),
      .perm_arr(st_perm),
      .hit     (lk_hit[p]),
      .ppn     (lk_ppn[p*PPN_W +: PPN_W]),
      .perm    (sel_perm)
    );

    assign lk_perm[p*PERM_W +: PERM_W]   = sel_perm;
    assign lk_way_hit[p*NWAYS +: NWAYS] = way_hit;
  end
endmodule

// File: rtl/mlt_array_chk.sv
module mlt_array_chk
  import mlt_pkg::*;
#(
  parameter int NWAYS       = 8,
  parameter int NPORTS      = 2,
  parameter int ASID_W      = 16,
  parameter int PPN_W       = 24,
  parameter bit IGNORE_ASID = 1'b0,
  localparam int WAY_W = (NWAYS > 1) ? $clog2(NWAYS) : 1
) (
  input logic                     clk,
  input logic                     rst,
  input logic [NPORTS*VPN_W-1:0]  lk_vpn,
  input logic [NPORTS*ASID_W-1:0] lk_asid,
  input logic [NPORTS-1:0]        lk_hit,
  input logic [NPORTS*PPN_W-1:0]  lk_ppn,
  input logic [NPORTS*PERM_W-1:0] lk_perm,
  input logic [NPORTS*NWAYS-1:0]  lk_way_hit,
  input logic                     rf_valid,
  input logic [WAY_W-1:0]         rf_way,
  input logic [VPN_W-1:0]         rf_vpn,
  input logic [ASID_W-1:0]        rf_asid,
  input logic [LVL_W-1:0]         rf_level,
  input logic                     fl_valid,
  input logic                     fl_use_asid,
  input logic [ASID_W-1:0]        fl_asid
);
  AST_FULL_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    (fl_valid && !fl_use_asid && !rf_valid) |=> (lk_way_hit == '0)); // R8

  for (genvar p = 0; p < NPORTS; p++) begin : g_chk
    AST_REFILL_VISIBLE: assert property (@(posedge clk) disable iff (rst)
      (rf_valid && rf_level != 2'd3 && 32'(rf_way) < NWAYS) |=>
      ((lk_vpn[p*VPN_W +: VPN_W] == $past(rf_vpn) &&
        lk_asid[p*ASID_W +: ASID_W] == $past(rf_asid)) ->
       lk_way_hit[p*NWAYS + 32'($past(rf_way))])); // R7

    AST_MISS_IS_QUIET: assert property (@(posedge clk) disable iff (rst)
      !lk_hit[p] |-> (lk_ppn[p*PPN_W +: PPN_W] == '0 &&
                      lk_perm[p*PERM_W +: PERM_W] == '0)); // R1

    AST_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (rst)
      (!rf_valid && !fl_valid) |=>
      (($stable(lk_vpn[p*VPN_W +: VPN_W]) && $stable(lk_asid[p*ASID_W +: ASID_W])) ->
       ($stable(lk_hit[p]) && $stable(lk_ppn[p*PPN_W +: PPN_W]) &&
        $stable(lk_way_hit[p*NWAYS +: NWAYS])))); // R11

    if (!IGNORE_ASID) begin : g_asid_flush
      AST_ASID_FLUSH_KEEPS_GLOBAL: assert property (@(posedge clk) disable iff (rst)
        (fl_valid && fl_use_asid && !rf_valid) |=>
        ((lk_hit[p] && lk_asid[p*ASID_W +: ASID_W] == $past(fl_asid)) ->
         lk_perm[p*PERM_W + G_BIT])); // R9
    end
  end
endmodule

bind mlt_array mlt_array_chk #(
  .NWAYS      (NWAYS),
  .NPORTS     (NPORTS),
  .ASID_W     (ASID_W),
  .PPN_W      (PPN_W),
  .IGNORE_ASID(IGNORE_ASID)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .lk_vpn     (lk_vpn),
  .lk_asid    (lk_asid),
  .lk_hit     (lk_hit),
  .lk_ppn     (lk_ppn),
  .lk_perm    (lk_perm),
  .lk_way_hit (lk_way_hit),
  .rf_valid   (rf_valid),
  .rf_way     (rf_way),
  .rf_vpn     (rf_vpn),
  .rf_asid    (rf_asid),
  .rf_level   (rf_level),
  .fl_valid   (fl_valid),
  .fl_use_asid(fl_use_asid),
  .fl_asid    (fl_asid)
);

// File: tb/mlt_array_bench.sv
module mlt_array_bench;
  localparam int CLK_P  = 10;
  localparam int NW     = 4;
  localparam int NP     = 2;
  localparam int AW     = 4;
  localparam int PW     = 20;
  localparam int VW     = 27;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NP*VW-1:0] lk_vpn = '0;
  logic [NP*AW-1:0] lk_asid = '0;
  logic [NP-1:0]    lk_hit;
  logic [NP*PW-1:0] lk_ppn;
  logic [NP*9-1:0]  lk_perm;
  logic [NP*NW-1:0] lk_way_hit;
  logic            rf_valid = 1'b0;
  logic [1:0]      rf_way = '0;
  logic [VW-1:0]   rf_vpn = '0;
  logic [AW-1:0]   rf_asid = '0;
  logic [1:0]      rf_level = '0;
  logic [PW-1:0]   rf_ppn = '0;
  logic [6:0]      rf_perm = '0;
  logic            rf_pf = 1'b0;
  logic            rf_af = 1'b0;
  logic            fl_valid = 1'b0;
  logic            fl_use_asid = 1'b0;
  logic [AW-1:0]   fl_asid = '0;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  // Reference contents, maintained from the requirements.
  logic          m_v    [NW];
  logic [VW-1:0] m_vpn  [NW];
  logic [AW-1:0] m_asid [NW];
  logic [1:0]    m_lvl  [NW];
  logic [PW-1:0] m_ppn  [NW];
  logic [8:0]    m_perm [NW];

  always #(CLK_P/2) clk = ~clk;

  mlt_array #(.NWAYS(NW), .NPORTS(NP), .ASID_W(AW), .PPN_W(PW)) u_mlt_array (
    .clk(clk), .rst(rst), .lk_vpn(lk_vpn), .lk_asid(lk_asid), .lk_hit(lk_hit),
    .lk_ppn(lk_ppn), .lk_perm(lk_perm), .lk_way_hit(lk_way_hit),
    .rf_valid(rf_valid), .rf_way(rf_way), .rf_vpn(rf_vpn), .rf_asid(rf_asid),
    .rf_level(rf_level), .rf_ppn(rf_ppn), .rf_perm(rf_perm), .rf_pf(rf_pf),
    .rf_af(rf_af), .fl_valid(fl_valid), .fl_use_asid(fl_use_asid), .fl_asid(fl_asid)
  );

  task automatic model(input logic [VW-1:0] v, input logic [AW-1:0] a,
                       output logic hit, output logic [PW-1:0] ppn,
                       output logic [8:0] perm, output logic [NW-1:0] vec);
    hit = 1'b0; ppn = '0; perm = '0; vec = '0;
    for (int w = 0; w < NW; w++) begin
      if (m_v[w] && m_lvl[w] != 2'd3 && m_asid[w] == a) begin
        int keep = (2 - int'(m_lvl[w])) * 9;
        if ((v >> keep) == (m_vpn[w] >> keep)) begin
          vec[w] = 1'b1;
          if (!hit) begin
            hit  = 1'b1;
            ppn  = PW'(((m_ppn[w] >> keep) << keep) | (v & ((27'd1 << keep) - 27'd1)));
            perm = m_perm[w];
          end
        end
      end
    end
  endtask

  task automatic check_port(input int p, input logic [VW-1:0] v,
                            input logic [AW-1:0] a, input string rq);
    logic eh; logic [PW-1:0] ep; logic [8:0] em; logic [NW-1:0] ev;
    model(v, a, eh, ep, em, ev);
    n_chk++;
    if (lk_hit[p] !== eh || lk_ppn[p*PW +: PW] !== ep ||
        lk_perm[p*9 +: 9] !== em || lk_way_hit[p*NW +: NW] !== ev) begin
      n_fail++;
      $display("FAIL %s port%0d vpn=%h asid=%h: got hit=%b ppn=%h perm=%h vec=%b exp hit=%b ppn=%h perm=%h vec=%b",
               rq, p, v, a, lk_hit[p], lk_ppn[p*PW +: PW], lk_perm[p*9 +: 9],
               lk_way_hit[p*NW +: NW], eh, ep, em, ev);
    end
  endtask

  // Both ports probed at once with different requests (R11).
  task automatic probe2(input logic [VW-1:0] v0, input logic [AW-1:0] a0,
                        input logic [VW-1:0] v1, input logic [AW-1:0] a1,
                        input string rq);
    @(negedge clk);
    lk_vpn  = {v1, v0};
    lk_asid = {a1, a0};
    #1;
    check_port(0, v0, a0, rq);
    check_port(1, v1, a1, {rq, " R11"});
  endtask

  task automatic refill(input int w, input logic [VW-1:0] v, input logic [AW-1:0] a,
                        input logic [1:0] l, input logic [PW-1:0] pp,
                        input logic [6:0] pm, input logic pf, input logic af);
    @(negedge clk);
    rf_valid = 1'b1; rf_way = 2'(w); rf_vpn = v; rf_asid = a; rf_level = l;
    rf_ppn = pp; rf_perm = pm; rf_pf = pf; rf_af = af;
    @(negedge clk);
    rf_valid = 1'b0;
    m_v[w] = 1'b1; m_vpn[w] = v; m_asid[w] = a; m_lvl[w] = l;
    m_ppn[w] = pp; m_perm[w] = {pf, af, pm};
  endtask

  task automatic model_flush(input logic use_a, input logic [AW-1:0] a);
    for (int w = 0; w < NW; w++)
      if (!use_a || (m_asid[w] == a && !m_perm[w][4])) m_v[w] = 1'b0;
  endtask

  task automatic flush(input logic use_a, input logic [AW-1:0] a);
    @(negedge clk);
    fl_valid = 1'b1; fl_use_asid = use_a; fl_asid = a;
    @(negedge clk);
    fl_valid = 1'b0;
    model_flush(use_a, a);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
    end
  end

  initial begin
    for (int w = 0; w < NW; w++) begin
      m_v[w] = 1'b0; m_vpn[w] = '0; m_asid[w] = '0;
      m_lvl[w] = '0; m_ppn[w] = '0; m_perm[w] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1: nothing valid after reset
    probe2(27'h0, 4'h0, 27'h7FFFFFF, 4'hF, "R1");
    probe2(27'h1234567, 4'h3, 27'h0ABCDEF, 4'h5, "R1");

    // One entry per level, plus an invalid level code.
    refill(0, 27'h5A3C1E7, 4'h3, 2'd0, 20'hABCDE, 7'b1100011, 1'b1, 1'b0);
    refill(1, 27'h2F0F0F0, 4'h3, 2'd1, 20'h13579, 7'b0010101, 1'b0, 1'b1);
    refill(2, 27'h7123456, 4'h5, 2'd2, 20'hFEDCB, 7'b1111111, 1'b0, 1'b0);
    refill(3, 27'h0444444, 4'h3, 2'd3, 20'h22222, 7'b0000001, 1'b0, 1'b0);

    // R2 R4 R5: each tag and every single-bit variant of it
    for (int w = 0; w < NW; w++) begin
      for (int k = -1; k < VW; k++) begin
        logic [VW-1:0] v = m_vpn[w] ^ ((k < 0) ? 27'd0 : (27'd1 << k));
        probe2(v, m_asid[w], ~v, m_asid[(w + 1) % NW], "R2 R4 R5");
      end
    end

    // R3: same tags under another address space
    for (int w = 0; w < NW; w++)
      probe2(m_vpn[w], m_asid[w] ^ 4'h1, m_vpn[w], m_asid[w] ^ 4'h8, "R3");

    // R6: an overlapping 4 KB entry in a higher way; lower way wins
    refill(3, 27'h7123456, 4'h5, 2'd2, 20'h0BEEF, 7'b0000010, 1'b1, 1'b1);
    probe2(27'h7123456, 4'h5, 27'h5A00000, 4'h3, "R6");
    refill(3, 27'h5A11111, 4'h3, 2'd2, 20'h0F00D, 7'b0000100, 1'b0, 1'b0);
    probe2(27'h5A11111, 4'h3, 27'h5A11112, 4'h3, "R6");

    // R7: lookup in the refill cycle sees the old contents
    @(negedge clk);
    rf_valid = 1'b1; rf_way = 2'd1; rf_vpn = 27'h3333333; rf_asid = 4'h9;
    rf_level = 2'd2; rf_ppn = 20'h77777; rf_perm = 7'b0100110; rf_pf = 1'b0; rf_af = 1'b0;
    lk_vpn = {27'h2F0F0F0, 27'h3333333}; lk_asid = {4'h3, 4'h9};
    #1;
    check_port(0, 27'h3333333, 4'h9, "R7 before");
    check_port(1, 27'h2F0F0F0, 4'h3, "R7 before");
    @(negedge clk);
    rf_valid = 1'b0;
    m_v[1] = 1'b1; m_vpn[1] = 27'h3333333; m_asid[1] = 4'h9; m_lvl[1] = 2'd2;
    m_ppn[1] = 20'h77777; m_perm[1] = 9'b000100110;
    #1;
    check_port(0, 27'h3333333, 4'h9, "R7 after");
    check_port(1, 27'h2F0F0F0, 4'h3, "R7 after");

    // R9: selective flush; way 1 becomes a global entry of ID 3
    refill(1, 27'h2F0F0F0, 4'h3, 2'd1, 20'h13579, 7'b0010000, 1'b0, 1'b0);
    flush(1'b1, 4'h3);
    probe2(27'h5A3C1E7, 4'h3, 27'h2F0F123, 4'h3, "R9");
    probe2(27'h7123456, 4'h5, 27'h5A11111, 4'h3, "R9");

    // R10: refill and full flush in the same cycle
    @(negedge clk);
    fl_valid = 1'b1; fl_use_asid = 1'b0;
    rf_valid = 1'b1; rf_way = 2'd2; rf_vpn = 27'h0101010; rf_asid = 4'hA;
    rf_level = 2'd1; rf_ppn = 20'h5A5A5; rf_perm = 7'b1000001; rf_pf = 1'b0; rf_af = 1'b1;
    @(negedge clk);
    fl_valid = 1'b0; rf_valid = 1'b0;
    model_flush(1'b0, 4'h0);
    m_v[2] = 1'b1; m_vpn[2] = 27'h0101010; m_asid[2] = 4'hA; m_lvl[2] = 2'd1;
    m_ppn[2] = 20'h5A5A5; m_perm[2] = 9'b011000001;
    probe2(27'h01010FF, 4'hA, 27'h2F0F0F0, 4'h3, "R10");

    // R8: full flush empties everything
    refill(0, 27'h6666666, 4'h1, 2'd2, 20'h12345, 7'b0010000, 1'b0, 1'b0);
    flush(1'b0, 4'h0);
    probe2(27'h6666666, 4'h1, 27'h0101010, 4'hA, "R8");

    finish_run();
  end
endmodule